// File: doc/BRIEF.md
# Delayed-Read Bus Target Bridge

This block is a target that connects a 32-bit host request port to a slower 16-bit local bus. The local bus runs on its own clock. Host writes are posted: each enabled 16-bit half becomes one entry in a write queue, and the queue drains to the local bus one word per local write cycle. Host reads never complete on their first attempt. The target answers with a retry and records the read as a single pending request. It carries out the needed local reads, keeps the 32-bit result, and hands the result over when the host repeats the same read.

A pending request can be created only while the write queue is empty. A host that reads straight after a burst of writes is therefore retried until every earlier write has reached the local bus. A small status window in the register space is answered on the first attempt and does not use the pending-request path, so software can poll the queue state there. Some reads have no enabled local data: no byte lane enabled, or only the upper half of the register window. These still go through the retry step, then return zero without touching the local bus.

Commands cross to the local clock through a toggle handshake with a two-flop synchroniser in each direction. The command and the result stay stable while their toggle is in flight.

Top module: `drr_bridge`

## Requirements
- R1: A read outside the status window never completes on its first attempt. The response is a retry, and when the request slot is free and the write queue is empty the read is recorded as the pending request.
- R2: While the write queue holds any entry, every read outside the status window is retried and no request is recorded. A local read never starts before all writes accepted earlier have finished on the local bus.
- R3: A repeated read whose window, 32-bit address and byte enables all equal the pending request returns the held data without retry once the local side has finished, and frees the slot. Any other read is retried and leaves the pending request and its data unchanged.
- R4: Reads of register-window byte offsets 0x800 to 0x81C complete on the first attempt. At offset 0x800, bit 30 is 1 exactly when the write queue is non-empty and bits [5:0] hold the queue fill count. Every other bit and every other offset in the window reads as zero.
- R5: A write to the memory window queues its low half and then its high half, one entry for each half whose byte enables are non-zero. A register-window write queues only its low half. Writes to the status window, and register writes with only upper lanes enabled, are accepted and discarded. The queue holds 32 entries. A write that needs more entries than are free is retried and dropped. Entries reach the local bus in order.
- R6: A read with all byte enables low, or a register-window read with byte enables [1:0] both low, is retried first and then returns zero, with no local-bus access.
- R7: A memory-window read with both halves enabled performs two local reads, at the even word address (byte address bits [11:2] followed by 0) and then the odd one, and returns {odd, even}. A low-half-only read returns the even word in [15:0]. A high-half-only read returns the odd word in [31:16]. A register-window read returns the even word in [15:0] with zeros above.
- R8: lb_stb stays high, with lb_addr and lb_we unchanged, until the cycle in which lb_ack is sampled high.
- R9: rsp_valid is high exactly one host clock after each cycle with req_valid high and low otherwise, well inside the five-clock termination limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host reset, active low, asynchronous assert |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 1 | 0 = memory window, 1 = register window |
| req_addr | input | 12 | Byte address within the window |
| req_be | input | 4 | Byte enables, active high |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_retry | output | 1 | Request terminated with retry |
| rsp_rdata | output | 32 | Read data when not retried |
| lclk | input | 1 | Local bus clock |
| lrst_n | input | 1 | Local reset, active low, asynchronous assert |
| lb_stb | output | 1 | Local access request |
| lb_we | output | 1 | Local access is a write |
| lb_win | output | 1 | Local window select |
| lb_addr | output | 11 | Local 16-bit word address |
| lb_wdata | output | 16 | Local write data |
| lb_rdata | input | 16 | Local read data, valid with lb_ack |
| lb_ack | input | 1 | Local access complete |

## Verification
Some properties are checked by assertions on every cycle. These are the response timing of each request, first-attempt completion of status reads, zero data on the zero-return reads, the rule that a request is recorded only after a cycle with an empty queue, the queue-fill bound, and the local strobe hold. Other behaviour needs the bench scenarios, because it spans both clocks and many attempts. These are the retry loop that lasts until a full queue has drained, the order of write entries against the local reads, the assembly of the two halves, and a mismatched repeat leaving the pending request intact.

// File: rtl/drr_pkg.sv
package drr_pkg;
  parameter int unsigned HA_W = 12;

  typedef enum logic [1:0] {OP_WR, OP_RD_LO, OP_RD_HI, OP_RD_DW} op_e;

  typedef struct packed {
    logic            win;
    logic [HA_W-2:0] waddr;
    logic [15:0]     data;
  } wentry_t;

  typedef struct packed {
    op_e             op;
    logic            win;
    logic [HA_W-2:0] waddr;
    logic [15:0]     wdata;
  } cmd_t;

  typedef enum logic [1:0] {S_FREE, S_WAIT, S_BUSY, S_DONE} slot_e;
endpackage

// File: rtl/drr_sync2.sv
module drr_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q      <= 1'b0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/drr_wfifo.sv
module drr_wfifo
  import drr_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 push_cnt,
  input  wentry_t                    push_a,
  input  wentry_t                    push_b,
  input  logic                       pop,
  output wentry_t                    head,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  wentry_t         mem [DEPTH];
  logic [PW-1:0]   wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q + PW'(push_cnt);
    rp_d  = rp_q + PW'(pop);
    cnt_d = cnt_q + CW'(push_cnt) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_cnt != 2'd0) mem[wp_q] <= push_a;
    if (push_cnt == 2'd2) mem[wp_q + PW'(1)] <= push_b;
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/drr_lcl_engine.sv
module drr_lcl_engine
  import drr_pkg::*;
(
  input  logic            lclk,
  input  logic            lrst_n,
  input  logic            req_s,
  input  cmd_t            cmd,
  output logic            ack_tgl,
  output logic [31:0]     result,
  output logic            lb_stb,
  output logic            lb_we,
  output logic            lb_win,
  output logic [HA_W-2:0] lb_addr,
  output logic [15:0]     lb_wdata,
  input  logic [15:0]     lb_rdata,
  input  logic            lb_ack
);
  typedef enum logic [1:0] {E_IDLE, E_FIRST, E_SECOND} est_e;

  est_e            st_q, st_d;
  logic            seen_q, seen_d, ack_q, ack_d, win_q, win_d;
  op_e             op_q, op_d;
  logic [HA_W-2:0] addr_q, addr_d;
  logic [15:0]     wd_q, wd_d;
  logic [31:0]     res_q, res_d;

  always_comb begin
    st_d = st_q; seen_d = seen_q; ack_d = ack_q; win_d = win_q;
    op_d = op_q; addr_d = addr_q; wd_d = wd_q; res_d = res_q;
    case (st_q)
      E_IDLE: if (req_s != seen_q) begin
        seen_d = req_s;
        op_d   = cmd.op;
        win_d  = cmd.win;
        wd_d   = cmd.wdata;
        addr_d = (cmd.op == OP_RD_HI) ? {cmd.waddr[HA_W-2:1], 1'b1} : cmd.waddr;
        st_d   = E_FIRST;
      end
      E_FIRST: if (lb_ack) begin
        case (op_q)
          OP_RD_LO: res_d = {16'h0000, lb_rdata};
          OP_RD_HI: res_d = {lb_rdata, 16'h0000};
          OP_RD_DW: res_d = {res_q[31:16], lb_rdata};
          default:  res_d = res_q;
        endcase
        if (op_q == OP_RD_DW) begin
          addr_d = {addr_q[HA_W-2:1], 1'b1};
          st_d   = E_SECOND;
        end else begin
          ack_d = ~ack_q;
          st_d  = E_IDLE;
        end
      end
      E_SECOND: if (lb_ack) begin
        res_d = {lb_rdata, res_q[15:0]};
        ack_d = ~ack_q;
        st_d  = E_IDLE;
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge lclk or negedge lrst_n) begin
    if (!lrst_n) begin
      st_q <= E_IDLE; seen_q <= 1'b0; ack_q <= 1'b0; win_q <= 1'b0;
      op_q <= OP_WR;  addr_q <= '0;   wd_q <= '0;    res_q <= '0;
    end else begin
      st_q <= st_d; seen_q <= seen_d; ack_q <= ack_d; win_q <= win_d;
      op_q <= op_d; addr_q <= addr_d; wd_q <= wd_d;   res_q <= res_d;
    end
  end

  assign lb_stb   = (st_q != E_IDLE);
  assign lb_we    = (op_q == OP_WR);
  assign lb_win   = win_q;
  assign lb_addr  = addr_q;
  assign lb_wdata = wd_q;
  assign ack_tgl  = ack_q;
  assign result   = res_q;
endmodule

// File: rtl/drr_bridge.sv
module drr_bridge
  import drr_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32
) (
  input  logic            hclk,
  input  logic            hrst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_win,
  input  logic [HA_W-1:0] req_addr,
  input  logic [3:0]      req_be,
  input  logic [31:0]     req_wdata,
  output logic            rsp_valid,
  output logic            rsp_retry,
  output logic [31:0]     rsp_rdata,
  input  logic            lclk,
  input  logic            lrst_n,
  output logic            lb_stb,
  output logic            lb_we,
  output logic            lb_win,
  output logic [HA_W-2:0] lb_addr,
  output logic [15:0]     lb_wdata,
  input  logic [15:0]     lb_rdata,
  input  logic            lb_ack
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH) + 1;
  localparam logic [HA_W-1:0] STAT_LO = HA_W'(12'h800);
  localparam logic [HA_W-1:0] STAT_HI = HA_W'(12'h81C);

  // write queue
  logic [CW-1:0] fifo_cnt;
  wentry_t       fifo_head, push_a, push_b;
  logic [1:0]    push_cnt;
  logic          fifo_pop;

  // pending request slot
  slot_e           slot_st_q, slot_st_d;
  logic            slot_win_q, slot_win_d;
  logic [HA_W-3:0] slot_dw_q, slot_dw_d;
  logic [3:0]      slot_be_q, slot_be_d;
  op_e             slot_op_q, slot_op_d;
  logic [31:0]     slot_data_q, slot_data_d;
  logic            slot_free;

  // clock crossing
  logic        h_tgl_q, h_tgl_d, ack_s, req_s, lcl_ack_tgl, busy, busy_q, done_evt;
  cmd_t        cmd_q, cmd_d;
  logic [31:0] lcl_result;

  // response
  logic        rsp_valid_q, rsp_retry_q, rsp_retry_d;
  logic [31:0] rsp_data_q, rsp_data_d;

  // request decode
  logic        is_stat, hit, rd_zero, lo_en, hi_en;
  op_e         rd_op;
  logic [31:0] stat_word;
  logic [1:0]  wr_words;
  wentry_t     lo_ent, hi_ent;

  assign busy      = h_tgl_q ^ ack_s;
  assign done_evt  = busy_q & ~busy;
  assign slot_free = (slot_st_q == S_FREE);
  assign is_stat   = req_win && (req_addr >= STAT_LO) && (req_addr <= STAT_HI);
  assign hit       = !slot_free && (slot_win_q == req_win) &&
                     (slot_dw_q == req_addr[HA_W-1:2]) && (slot_be_q == req_be);
  assign rd_zero   = (req_be == 4'h0) || (req_win && (req_be[1:0] == 2'b00));
  assign lo_en     = (req_be[1:0] != 2'b00);
  assign hi_en     = (req_be[3:2] != 2'b00) && !req_win;
  assign wr_words  = {1'b0, lo_en} + {1'b0, hi_en};
  assign lo_ent    = '{win: req_win, waddr: {req_addr[HA_W-1:2], 1'b0}, data: req_wdata[15:0]};
  assign hi_ent    = '{win: req_win, waddr: {req_addr[HA_W-1:2], 1'b1}, data: req_wdata[31:16]};

  always_comb begin
    if (req_win) rd_op = OP_RD_LO;
    else if (lo_en && (req_be[3:2] != 2'b00)) rd_op = OP_RD_DW;
    else if (lo_en) rd_op = OP_RD_LO;
    else rd_op = OP_RD_HI;
    stat_word = '0;
    if (req_addr == STAT_LO) begin
      stat_word[30]     = (fifo_cnt != '0);
      stat_word[CW-1:0] = fifo_cnt;
    end
  end

  always_comb begin
    slot_st_d = slot_st_q; slot_win_d = slot_win_q; slot_dw_d = slot_dw_q;
    slot_be_d = slot_be_q; slot_op_d = slot_op_q;   slot_data_d = slot_data_q;
    h_tgl_d = h_tgl_q; cmd_d = cmd_q; fifo_pop = 1'b0;
    push_cnt = 2'd0; push_a = lo_en ? lo_ent : hi_ent; push_b = hi_ent;
    rsp_retry_d = 1'b0; rsp_data_d = '0;

    if (done_evt && (slot_st_q == S_BUSY)) begin
      slot_st_d   = S_DONE;
      slot_data_d = lcl_result;
    end

    if (!busy) begin
      if (slot_st_q == S_WAIT) begin
        cmd_d.op    = slot_op_q;
        cmd_d.win   = slot_win_q;
        cmd_d.waddr = {slot_dw_q, 1'b0};
        cmd_d.wdata = '0;
        h_tgl_d     = ~h_tgl_q;
        slot_st_d   = S_BUSY;
      end else if (fifo_cnt != '0) begin
        cmd_d.op    = OP_WR;
        cmd_d.win   = fifo_head.win;
        cmd_d.waddr = fifo_head.waddr;
        cmd_d.wdata = fifo_head.data;
        h_tgl_d     = ~h_tgl_q;
        fifo_pop    = 1'b1;
      end
    end

    if (req_valid && !req_write) begin
      if (is_stat) begin
        rsp_data_d = stat_word;
      end else if (hit && (slot_st_q == S_DONE)) begin
        rsp_data_d = slot_data_q;
        slot_st_d  = S_FREE;
      end else begin
        rsp_retry_d = 1'b1;
        if (slot_free && (fifo_cnt == '0)) begin
          slot_win_d  = req_win;
          slot_dw_d   = req_addr[HA_W-1:2];
          slot_be_d   = req_be;
          slot_op_d   = rd_op;
          slot_data_d = '0;
          slot_st_d   = rd_zero ? S_DONE : S_WAIT;
        end
      end
    end else if (req_valid && req_write && !is_stat) begin
      if ((32'(fifo_cnt) + 32'(wr_words)) <= FIFO_DEPTH) push_cnt = wr_words;
      else rsp_retry_d = 1'b1;
    end
  end

  always_ff @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n) begin
      slot_st_q <= S_FREE; slot_win_q <= 1'b0; slot_dw_q <= '0;
      slot_be_q <= '0;     slot_op_q <= OP_WR; slot_data_q <= '0;
      h_tgl_q <= 1'b0; busy_q <= 1'b0; cmd_q <= '0;
      rsp_valid_q <= 1'b0; rsp_retry_q <= 1'b0; rsp_data_q <= '0;
    end else begin
      slot_st_q <= slot_st_d; slot_win_q <= slot_win_d; slot_dw_q <= slot_dw_d;
      slot_be_q <= slot_be_d; slot_op_q <= slot_op_d;   slot_data_q <= slot_data_d;
      h_tgl_q <= h_tgl_d; busy_q <= busy; cmd_q <= cmd_d;
      rsp_valid_q <= req_valid; rsp_retry_q <= rsp_retry_d; rsp_data_q <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_retry = rsp_retry_q;
  assign rsp_rdata = rsp_data_q;

  drr_wfifo #(.DEPTH(FIFO_DEPTH)) u_wfifo (
    .clk(hclk), .rst_n(hrst_n), .push_cnt(push_cnt), .push_a(push_a),
    .push_b(push_b), .pop(fifo_pop), .head(fifo_head), .count(fifo_cnt)
  );

  drr_sync2 u_ack_sync (.clk(hclk), .rst_n(hrst_n), .d(lcl_ack_tgl), .q(ack_s));
  drr_sync2 u_req_sync (.clk(lclk), .rst_n(lrst_n), .d(h_tgl_q), .q(req_s));

  drr_lcl_engine u_lcl (
    .lclk(lclk), .lrst_n(lrst_n), .req_s(req_s), .cmd(cmd_q),
    .ack_tgl(lcl_ack_tgl), .result(lcl_result),
    .lb_stb(lb_stb), .lb_we(lb_we), .lb_win(lb_win), .lb_addr(lb_addr),
    .lb_wdata(lb_wdata), .lb_rdata(lb_rdata), .lb_ack(lb_ack)
  );
endmodule

// File: rtl/drr_bridge_chk.sv
module drr_bridge_chk
  import drr_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW    = 6
) (
  input logic            hclk,
  input logic            hrst_n,
  input logic            lclk,
  input logic            lrst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic            req_win,
  input logic [HA_W-1:0] req_addr,
  input logic [3:0]      req_be,
  input logic            rsp_valid,
  input logic            rsp_retry,
  input logic [31:0]     rsp_rdata,
  input logic            slot_free,
  input logic [CW-1:0]   fifo_cnt,
  input logic            lb_stb,
  input logic            lb_ack,
  input logic            lb_we,
  input logic [HA_W-2:0] lb_addr
);
  logic stat_rd, plain_rd, zero_rd;
  assign stat_rd  = req_valid && !req_write && req_win &&
                    (req_addr >= HA_W'(12'h800)) && (req_addr <= HA_W'(12'h81C));
  assign plain_rd = req_valid && !req_write && !stat_rd;
  assign zero_rd  = req_valid && !req_write &&
                    ((req_be == 4'h0) || (req_win && (req_be[1:0] == 2'b00)));

  a_r9_resp_follows: assert property (@(posedge hclk) disable iff (!hrst_n)
    req_valid |=> rsp_valid);
  a_r9_no_stray_resp: assert property (@(posedge hclk) disable iff (!hrst_n)
    !req_valid |=> !rsp_valid);
  a_r4_status_direct: assert property (@(posedge hclk) disable iff (!hrst_n)
    stat_rd |=> !rsp_retry);
  a_r1_first_try_retried: assert property (@(posedge hclk) disable iff (!hrst_n)
    (plain_rd && slot_free) |=> rsp_retry);
  a_r6_zero_data: assert property (@(posedge hclk) disable iff (!hrst_n)
    zero_rd |=> (rsp_retry || (rsp_rdata == 32'h0)));
  a_r2_gate_empty: assert property (@(posedge hclk) disable iff (!hrst_n)
    $fell(slot_free) |-> ($past(fifo_cnt) == '0));
  a_r5_fill_bound: assert property (@(posedge hclk) disable iff (!hrst_n)
    32'(fifo_cnt) <= DEPTH);
  a_r8_strobe_hold: assert property (@(posedge lclk) disable iff (!lrst_n)
    (lb_stb && !lb_ack) |=> (lb_stb && $stable(lb_addr) && $stable(lb_we)));
endmodule

bind drr_bridge drr_bridge_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .hclk(hclk), .hrst_n(hrst_n), .lclk(lclk), .lrst_n(lrst_n),
  .req_valid(req_valid), .req_write(req_write), .req_win(req_win),
  .req_addr(req_addr), .req_be(req_be), .rsp_valid(rsp_valid),
  .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata), .slot_free(slot_free),
  .fifo_cnt(fifo_cnt), .lb_stb(lb_stb), .lb_ack(lb_ack), .lb_we(lb_we),
  .lb_addr(lb_addr)
);

// File: tb/sim_drr_bridge.sv
`timescale 1ns/1ps
module sim_drr_bridge;
  import drr_pkg::*;

  logic hclk = 1'b0, lclk = 1'b0, hrst_n = 1'b0, lrst_n = 1'b0;
  always #2.5 hclk = ~hclk;
  always #6   lclk = ~lclk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_win = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_retry, lb_stb, lb_we, lb_win, lb_ack;
  logic [31:0] rsp_rdata;
  logic [10:0] lb_addr;
  logic [15:0] lb_wdata, lb_rdata;

  drr_bridge u0 (.*);

  int vecs = 0, fails = 0, lreads = 0;
  bit hold_ack = 1'b0;
  logic ack_r = 1'b0;
  logic [15:0] rd_r = '0;
  logic [15:0] lmem [2][2048];
  logic [27:0] wq [$];
  assign lb_ack   = ack_r;
  assign lb_rdata = rd_r;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  // local responder: acknowledges one cycle after a strobe is seen
  always @(posedge lclk) begin
    if (lb_stb && !ack_r && !hold_ack) begin
      ack_r <= 1'b1;
      if (lb_we) lmem[lb_win][lb_addr] <= lb_wdata;
      else rd_r <= lmem[lb_win][lb_addr];
    end else ack_r <= 1'b0;
  end

  // local monitor (reference queue of posted words)
  bit stb_p = 1'b0, ack_p = 1'b0;
  logic [10:0] addr_p = '0;
  always @(negedge lclk) begin
    if (lrst_n) begin
      if (stb_p && !ack_p)   // R8 strobe and address held
        chk(lb_stb && (lb_addr == addr_p), "R8", "strobe hold", {21'b0, lb_addr}, {21'b0, addr_p});
      if (lb_stb && ack_r) begin
        if (lb_we) begin
          if (wq.size() == 0) chk(1'b0, "R5", "unexpected local write", {4'b0, lb_win, lb_addr, lb_wdata}, 0);
          else begin
            logic [27:0] e;
            e = wq.pop_front();
            chk({lb_win, lb_addr, lb_wdata} == e, "R5", "drain order", {4'b0, lb_win, lb_addr, lb_wdata}, {4'b0, e});
          end
        end else begin
          lreads++;
          chk(wq.size() == 0, "R2", "local read before writes drained", wq.size(), 0);
        end
      end
    end
    stb_p  = lb_stb;
    ack_p  = ack_r;
    addr_p = lb_addr;
  end

  // R9: response one host clock after each request, checked every clock
  always @(posedge hclk) begin
    #1;
    if (hrst_n) chk(rsp_valid == req_valid, "R9", "response timing", {31'b0, rsp_valid}, {31'b0, req_valid});
  end

  task automatic do_req(input bit w, input bit win, input logic [11:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output bit retry, output logic [31:0] rd);
    @(negedge hclk);
    req_valid = 1'b1; req_write = w; req_win = win; req_addr = a; req_be = be; req_wdata = wd;
    @(negedge hclk);
    req_valid = 1'b0;
    retry = rsp_retry;
    rd = rsp_rdata;
  endtask

  task automatic post(input bit win, input logic [11:0] a, input logic [3:0] be,
                      input logic [31:0] wd, output bit retry);
    logic [31:0] rd;
    do_req(1'b1, win, a, be, wd, retry, rd);
    if (!retry && !(win && a >= 12'h800 && a <= 12'h81C)) begin
      if (be[1:0] != 0) wq.push_back({win, a[11:2], 1'b0, wd[15:0]});
      if (be[3:2] != 0 && !win) wq.push_back({win, a[11:2], 1'b1, wd[31:16]});
    end
  endtask

  task automatic read_done(input bit win, input logic [11:0] a, input logic [3:0] be,
                           output int tries, output logic [31:0] rd);
    bit r;
    tries = 0;
    do begin
      do_req(1'b0, win, a, be, 0, r, rd);
      tries++;
    end while (r && tries < 4000);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge hclk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit r;
    int t, lr0;
    logic [31:0] d, ex;
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 2048; i++) lmem[w][i] = 16'(i * 37 + w * 16'h4000 + 5);

    repeat (4) @(negedge hclk);
    chk(rsp_valid == 1'b0, "R9", "reset rsp_valid", {31'b0, rsp_valid}, 0);
    chk(lb_stb == 1'b0, "R8", "reset lb_stb", {31'b0, lb_stb}, 0);
    hrst_n = 1'b1; lrst_n = 1'b1;
    repeat (4) @(negedge hclk);

    // R4 status reads when idle
    do_req(0, 1, 12'h800, 4'hF, 0, r, d);
    chk(!r && d == 0, "R4", "status empty", d, 0);
    do_req(0, 1, 12'h804, 4'hF, 0, r, d);
    chk(!r && d == 0, "R4", "other status offset", d, 0);

    // fill the queue with the local side stalled
    hold_ack = 1'b1;
    for (int i = 0; i < 16; i++) begin
      post(0, 12'h100 + 12'(4 * i), 4'hF, {16'hB000 + 16'(i), 16'hA000 + 16'(i)}, r);
      chk(!r, "R5", "posted write accepted", {31'b0, r}, 0);
    end
    do_req(0, 1, 12'h800, 4'hF, 0, r, d);
    chk(!r && d == 32'h4000_001F, "R4", "status fill 31", d, 32'h4000_001F);
    post(0, 12'h180, 4'hF, 32'h5555_6666, r);
    chk(r, "R5", "dword write with one free entry retried", {31'b0, r}, 1);
    post(0, 12'h180, 4'h3, 32'h0000_1234, r);
    chk(!r, "R5", "single word fills last entry", {31'b0, r}, 0);
    do_req(0, 1, 12'h800, 4'hF, 0, r, d);
    chk(!r && d == 32'h4000_0020, "R4", "status full", d, 32'h4000_0020);
    do_req(0, 0, 12'h100, 4'hF, 0, r, d);
    chk(r, "R2", "read while queue full retried", {31'b0, r}, 1);

    // release drain; repeated read completes only after the drain
    hold_ack = 1'b0;
    read_done(0, 12'h100, 4'hF, t, d);
    chk(t > 5, "R2", "retries during drain", t, 6);
    chk(d == 32'hB000_A000, "R7", "dword assembly", d, 32'hB000_A000);
    chk(wq.size() == 0, "R5", "all posted words drained", wq.size(), 0);

    // single-half reads
    do_req(0, 0, 12'h104, 4'h3, 0, r, d);
    chk(r, "R1", "first attempt retried", {31'b0, r}, 1);
    read_done(0, 12'h104, 4'h3, t, d);
    chk(d == 32'h0000_A001, "R7", "low half read", d, 32'h0000_A001);
    read_done(0, 12'h108, 4'hC, t, d);
    chk(d == 32'hB002_0000, "R7", "high half read", d, 32'hB002_0000);

    // zero-return cases
    lr0 = lreads;
    do_req(0, 0, 12'h200, 4'h0, 0, r, d);
    chk(r, "R6", "no-enable read first retried", {31'b0, r}, 1);
    read_done(0, 12'h200, 4'h0, t, d);
    chk(d == 0, "R6", "no-enable read data", d, 0);
    read_done(1, 12'h010, 4'hC, t, d);
    chk(d == 0, "R6", "register upper word data", d, 0);
    repeat (20) @(negedge hclk);
    chk(lreads == lr0, "R6", "no local access", lreads, lr0);

    // register lower word
    read_done(1, 12'h010, 4'hF, t, d);
    ex = {16'h0, lmem[1][8]};
    chk(d == ex, "R7", "register read", d, ex);
    chk(lreads == lr0 + 1, "R7", "one local read", lreads, lr0 + 1);

    // discarded writes leave the queue empty
    post(1, 12'h804, 4'hF, 32'hFFFF_FFFF, r);
    post(1, 12'h020, 4'hC, 32'hFFFF_FFFF, r);
    do_req(0, 1, 12'h800, 4'hF, 0, r, d);
    chk(!r && d == 0, "R5", "discarded writes queue nothing", d, 0);

    // mismatched repeat does not disturb the pending request
    do_req(0, 0, 12'h300, 4'hF, 0, r, d);
    chk(r, "R1", "read A queued with retry", {31'b0, r}, 1);
    do_req(0, 0, 12'h304, 4'hF, 0, r, d);
    chk(r, "R3", "read B retried", {31'b0, r}, 1);
    do_req(0, 1, 12'h81C, 4'hF, 0, r, d);
    chk(!r && d == 0, "R4", "status direct while pending", d, 0);
    repeat (200) @(negedge hclk);
    do_req(0, 0, 12'h304, 4'hF, 0, r, d);
    chk(r, "R3", "read B still retried", {31'b0, r}, 1);
    do_req(0, 0, 12'h300, 4'h3, 0, r, d);
    chk(r, "R3", "other byte enables retried", {31'b0, r}, 1);
    do_req(0, 0, 12'h300, 4'hF, 0, r, d);
    ex = {lmem[0][12'h181], lmem[0][12'h180]};
    chk(!r && d == ex, "R3", "read A completes with held data", d, ex);
    read_done(0, 12'h304, 4'hF, t, d);
    ex = {lmem[0][12'h183], lmem[0][12'h182]};
    chk(d == ex, "R3", "slot freed, read B completes", d, ex);

    repeat (10) @(negedge hclk);
    finish_run();
  end
endmodule